// File: doc/BRIEF.md
# Timer Interrupt Status Flag Register

This block holds the sticky event flags of a general-purpose timer that has four capture/compare channels. The timer core supplies strobes: counter overflow or underflow, software-requested update, trigger-input edges, a compare match per channel, a capture event per channel, and a read strobe per capture register. The core also supplies mode levels: update disable, update request select, gated slave mode, center-aligned counting, and input or output mode per channel. Each flag is set by the hardware and stays set until software writes a 0 to its bit. Software writes are a 16-bit data word qualified by a write enable.

A channel in input mode also loses its capture flag when its capture register is read. If a second capture arrives while that flag is still set, the channel's over-capture flag is raised. The update, trigger and channel flags are each gated by an enable input. The gated flags are ORed into one interrupt line, which is registered. The flag word is returned combinationally on a read data bus whenever a read is addressed.

Top module: `tim_irq_status`

## Requirements
- R1: While reset is asserted, and after it is released, every flag is 0 and `irq` is 0.
- R2: With `rd_en`=1, `rd_data` shows the current flags in the same cycle. Bit 0 is the update flag, bits 1..4 are the channel 1..4 flags, bit 6 is the trigger flag and bits 9..12 are the channel 1..4 over-capture flags. Bits 5, 7, 8 and 13..15 always read 0. With `rd_en`=0, `rd_data` is 0.
- R3: A write with `wr_en`=1 clears each flag whose bit in `wr_data` is 0. A flag whose bit is 1 keeps its value, and writes to reserved bits have no effect.
- R4: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R5: A channel in output mode (`ch_input` bit 0) sets its flag on `cmp_match`. It does not do so while `center_mode`=1.
- R6: A channel in input mode (`ch_input` bit 1) sets its flag on `cap_evt`. The flag is cleared by that channel's `ccr_rd` strobe.
- R7: A channel's over-capture flag is set when a capture occurs in input mode while the channel flag is already set. A capture that coincides with `ccr_rd` leaves the channel flag set and does not raise over-capture. Repeated compare matches in output mode never raise it.
- R8: With `gated_mode`=0, only `trg_rise` (the valid trigger edge) sets the trigger flag. With `gated_mode`=1, either `trg_rise` or `trg_fall` sets it.
- R9: With `upd_dis`=0, `upd_ovf` sets the update flag. `upd_sw` sets it only when both `upd_dis`=0 and `urs`=0. With `upd_dis`=1, nothing sets it.
- R10: `irq` equals, one clock later, the OR of the flags ANDed with `irq_en`. `irq_en` bit 0 is update, bits 1..4 are channels 1..4, and bit 5 is trigger. Over-capture flags do not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Write word; a 0 clears the flag in that bit |
| rd_en | input | 1 | Read addressed this cycle |
| rd_data | output | 16 | Flag word (combinational) |
| upd_ovf | input | 1 | Counter overflow/underflow strobe |
| upd_sw | input | 1 | Software update or reinitialisation strobe |
| upd_dis | input | 1 | Update disable level |
| urs | input | 1 | Update request select level |
| trg_rise | input | 1 | Valid trigger-input edge strobe |
| trg_fall | input | 1 | Opposite trigger-input edge strobe |
| gated_mode | input | 1 | Slave mode is gated |
| center_mode | input | 1 | Counter runs center-aligned |
| ch_input | input | 4 | Per channel: 1 = input capture, 0 = output compare |
| cmp_match | input | 4 | Per-channel compare match strobe |
| cap_evt | input | 4 | Per-channel capture strobe |
| ccr_rd | input | 4 | Per-channel capture register read strobe |
| irq_en | input | 6 | Interrupt enables: update, channels 1..4, trigger |
| irq | output | 1 | Registered combined interrupt |

## Verification
The update flag is driven with each combination of overflow and software update against the disable and request-select levels, which separates the two qualification rules. The channels are driven with single and repeated matches or captures in both directions of `ch_input`, and with center-aligned counting. This tells over-capture apart from plain re-setting and shows the compare path being suppressed. The trigger edges are applied in and out of gated mode. Clears are applied with mixed write masks, and set and clear are made to coincide to confirm that the set wins. The interrupt line is sampled both one cycle and two cycles after a flag sets, which shows its latency and its enable masking.

// File: rtl/tim_irq_status.sv
module tim_irq_status #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int CC_LSB = 1,
  localparam int TRG_BIT = 6,
  localparam int OC_LSB = 9,
  localparam int EN_W = NCH + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  output logic [DW-1:0]  rd_data,
  input  logic           upd_ovf,
  input  logic           upd_sw,
  input  logic           upd_dis,
  input  logic           urs,
  input  logic           trg_rise,
  input  logic           trg_fall,
  input  logic           gated_mode,
  input  logic           center_mode,
  input  logic [NCH-1:0] ch_input,
  input  logic [NCH-1:0] cmp_match,
  input  logic [NCH-1:0] cap_evt,
  input  logic [NCH-1:0] ccr_rd,
  input  logic [EN_W-1:0] irq_en,
  output logic           irq
);

  logic           upd_q, trg_q;
  logic [NCH-1:0] cc_q, oc_q;
  logic [DW-1:0]  flags;
  logic [DW-1:0]  clr;

  assign clr = wr_en ? ~wr_data : '0;

  logic upd_set, trg_set;
  assign upd_set = !upd_dis && (upd_ovf || (upd_sw && !urs));
  assign trg_set = trg_rise || (gated_mode && trg_fall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      trg_q <= 1'b0;
    end else begin
      upd_q <= upd_set || (upd_q && !clr[0]);
      trg_q <= trg_set || (trg_q && !clr[TRG_BIT]);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cc_set, cc_clr, oc_set;
    assign cc_set = ch_input[i] ? cap_evt[i] : (cmp_match[i] && !center_mode);
    assign cc_clr = clr[CC_LSB+i] || (ch_input[i] && ccr_rd[i]);
    assign oc_set = ch_input[i] && cap_evt[i] && cc_q[i] && !ccr_rd[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cc_q[i] <= 1'b0;
        oc_q[i] <= 1'b0;
      end else begin
        cc_q[i] <= cc_set || (cc_q[i] && !cc_clr);
        oc_q[i] <= oc_set || (oc_q[i] && !clr[OC_LSB+i]);
      end
    end

    assert_ovc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!oc_q[i] && !(ch_input[i] && cap_evt[i])) |=> !oc_q[i]);
    assert_center_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (center_mode && !ch_input[i] && !cc_q[i]) |=> !cc_q[i]);
    assert_ccr_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_input[i] && ccr_rd[i] && !cap_evt[i]) |=> !cc_q[i]);
  end

  always_comb begin
    flags = '0;
    flags[0] = upd_q;
    flags[TRG_BIT] = trg_q;
    flags[CC_LSB +: NCH] = cc_q;
    flags[OC_LSB +: NCH] = oc_q;
  end

  assign rd_data = rd_en ? flags : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(irq_en & {trg_q, cc_q, upd_q});
  end

  assert_sw_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0] && !upd_ovf && !upd_sw) |=> !upd_q);
  assert_hold_on_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !(wr_en && !wr_data[0])) |=> upd_q);
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ovf && !upd_dis) |=> upd_q);
  assert_upd_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dis && !upd_q) |=> !upd_q);
  assert_trg_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!trg_rise && !gated_mode && !trg_q) |=> !trg_q);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |=> !irq);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq && flags == '0));

endmodule

// File: tb/tb_tim_irq_status.sv
module tb_tim_irq_status;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 1;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic upd_ovf = 0, upd_sw = 0, upd_dis = 0, urs = 0;
  logic trg_rise = 0, trg_fall = 0, gated_mode = 0, center_mode = 0;
  logic [3:0] ch_input = '0, cmp_match = '0, cap_evt = '0, ccr_rd = '0;
  logic [5:0] irq_en = '0;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tim_irq_status dut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    upd_ovf = 0; upd_sw = 0; trg_rise = 0; trg_fall = 0;
    cmp_match = '0; cap_evt = '0; ccr_rd = '0; wr_en = 0; wr_data = '0;
  endtask

  task automatic wipe();
    wr_en = 1; wr_data = 16'h0000; step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 flags in reset", rd_data, 16'h0000);
    check("R1 irq in reset", {15'b0, irq}, 16'h0000);
    rst_n = 1;
    step();
    check("R1 flags after reset", rd_data, 16'h0000);
  endtask

  task automatic t_update();
    upd_ovf = 1; step();
    check("R9 overflow sets", rd_data, 16'h0001);
    wipe();
    upd_dis = 1; upd_ovf = 1; upd_sw = 1; step();
    check("R9 disabled", rd_data, 16'h0000);
    upd_dis = 0; urs = 1; upd_sw = 1; step();
    check("R9 sw update blocked by urs", rd_data, 16'h0000);
    upd_ovf = 1; step();
    check("R9 overflow with urs", rd_data, 16'h0001);
    wipe(); urs = 0; upd_sw = 1; step();
    check("R9 sw update", rd_data, 16'h0001);
    wipe();
  endtask

  task automatic t_write();
    upd_ovf = 1; trg_rise = 1; step();
    wr_en = 1; wr_data = 16'hFFFF; step();
    check("R3 write ones keeps", rd_data, 16'h0041);
    wr_en = 1; wr_data = 16'hFFFE; step();
    check("R3 clear bit 0 only", rd_data, 16'h0040);
    wipe();
    check("R3 clear all", rd_data, 16'h0000);
    wr_en = 1; wr_data = 16'hE1A0; step();
    check("R2 reserved bits stay zero", rd_data, 16'h0000);
  endtask

  task automatic t_setwins();
    upd_ovf = 1; step();
    upd_ovf = 1; wr_en = 1; wr_data = 16'h0000; step();
    check("R4 set beats clear", rd_data, 16'h0001);
    wipe();
  endtask

  task automatic t_compare();
    ch_input = 4'h0; cmp_match = 4'b0010; step();
    check("R5 ch2 compare", rd_data, 16'h0004);
    center_mode = 1; cmp_match = 4'b0100; step();
    check("R5 center suppresses", rd_data, 16'h0004);
    center_mode = 0; cmp_match = 4'b0010; step();
    check("R7 output repeat no over-capture", rd_data, 16'h0004);
    wipe();
  endtask

  task automatic t_capture();
    ch_input = 4'hF; cap_evt = 4'b0001; step();
    check("R6 capture sets ch1", rd_data, 16'h0002);
    ccr_rd = 4'b0001; step();
    check("R6 ccr read clears", rd_data, 16'h0000);
    cap_evt = 4'b1000; step();
    cap_evt = 4'b1000; step();
    check("R7 over-capture ch4", rd_data, 16'h1010);
    wr_en = 1; wr_data = 16'hEFFF; step();
    check("R3 clear over-capture only", rd_data, 16'h0010);
    wipe();
    cap_evt = 4'b0100; step();
    cap_evt = 4'b0100; ccr_rd = 4'b0100; step();
    check("R7 read with capture", rd_data, 16'h0008);
    wipe(); ch_input = 4'h0;
  endtask

  task automatic t_trigger();
    gated_mode = 0; trg_fall = 1; step();
    check("R8 fall ignored ungated", rd_data, 16'h0000);
    trg_rise = 1; step();
    check("R8 rise sets", rd_data, 16'h0040);
    wipe();
    gated_mode = 1; trg_fall = 1; step();
    check("R8 gated any edge", rd_data, 16'h0040);
    wipe(); gated_mode = 0;
  endtask

  task automatic t_irq();
    irq_en = 6'b000001; upd_ovf = 1; step();
    check("R10 irq latency low", {15'b0, irq}, 16'h0000);
    step();
    check("R10 irq high", {15'b0, irq}, 16'h0001);
    irq_en = 6'b111110; step(); step();
    check("R10 masked", {15'b0, irq}, 16'h0000);
    wipe();
    ch_input = 4'h1; cap_evt = 4'b0001; step();
    cap_evt = 4'b0001; step();
    wr_en = 1; wr_data = 16'hFFFD; irq_en = 6'b111111; step();
    step(); step();
    check("R10 over-capture no irq", {15'b0, irq}, 16'h0000);
    wipe(); ch_input = 4'h0;
  endtask

  task automatic t_read();
    trg_rise = 1; step();
    rd_en = 0; #1;
    check("R2 no read zero", rd_data, 16'h0000);
    rd_en = 1; #1;
    check("R2 read current", rd_data, 16'h0040);
    wipe();
  endtask

  initial begin
    fork
      begin
        t_reset(); t_update(); t_write(); t_setwins(); t_compare();
        t_capture(); t_trigger(); t_irq(); t_read();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule